// File: doc/BRIEF.md
# Packed Lane Replicate and Bit-Reverse Unit

This is a purely combinational execute-stage slice for a processor datapath with a 64-bit register width and packed-SIMD extensions. It receives an already decoded sub-operation code, a group select, the 10-bit immediate field of the instruction, the low word of one source register and the destination register index. In the same cycle it returns the value to write back, a write strobe and a flag for an unsupported sub-operation.

It performs two kinds of work. The first is reversing the bit order of the low 16 bits of the source. The second is broadcasting a byte, a halfword or a word into every lane of the result. The broadcast value comes either from the immediate or from the source register. The narrow group yields 32-bit results that are always sign-extended from bit 31. The wide group fills all 64 bits and is legal only when the mode input selects 64-bit operation.

Top module: `srx_repl_unit`

## Requirements
- R1: Narrow group, code 0x1B: result bit (15-i) equals source bit i for i = 0..15, and result bits 63:16 are zero.
- R2: Narrow group, code 0x02: the immediate bits 7:0 appear in all four bytes of the low word. Immediate bits 9:8 are ignored.
- R3: Narrow group, code 0x03: source bits 7:0 appear in all four bytes of the low word.
- R4: Narrow group, code 0x0A: the 10-bit immediate is sign-extended from its bit 9 to 16 bits and placed in both halfwords of the low word.
- R5: Narrow group, code 0x0B: source bits 15:0 are placed in both halfwords of the low word.
- R6: Every narrow-group replicate result has bits 63:32 equal to copies of bit 31.
- R7: Wide group, code 0x02 or 0x03: the byte (immediate bits 7:0 or source bits 7:0) fills all eight bytes.
- R8: Wide group, code 0x0A or 0x0B: the halfword (immediate sign-extended from bit 9, or source bits 15:0) fills all four halfwords.
- R9: Wide group, code 0x12 or 0x13: the word (immediate sign-extended from bit 9 to 32 bits, or source bits 31:0) fills both words.
- R10: A legal operation with destination index 0 drives the write strobe low and the invalid flag low. A nonzero index drives the strobe high.
- R11: Any code outside the legal set for its group raises the invalid flag, drives the write strobe low and drives the result to zero. This includes 0x12 in the narrow group and 0x1B in the wide group.
- R12: When the mode input is 0 (32-bit), every wide-group code is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_64 | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| op_group | input | 1 | 0 = narrow group, 1 = wide group |
| subop | input | 5 | Sub-operation code (instruction bits 10:6) |
| imm_field | input | 10 | Immediate (instruction bits 25:16) |
| src_lo | input | 32 | Low word of the source register |
| dest_idx | input | 5 | Destination register index |
| wr_data | output | 64 | Write-back value |
| wr_en | output | 1 | Write strobe |
| illegal_op | output | 1 | Unsupported sub-operation |

## Verification
Two conditions can meet on one set of inputs: suppression for a zero destination and detection of an illegal code. Each also appears together with a legal operation that targets register 0. The bench drives an illegal code with destination 0 and a legal code with destination 0. It expects the write strobe to be low in both cases, the invalid flag to be high only for the illegal code, and the result to be zero only for the illegal code. A wide-group code in 32-bit mode is also paired with a nonzero destination. This shows that the mode check alone blocks the write.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned SUBOP_W = 5;

    typedef enum logic [SUBOP_W-1:0] {
        SUB_BREV     = 5'h1B,
        SUB_BYTE_IMM = 5'h02,
        SUB_BYTE_REG = 5'h03,
        SUB_HALF_IMM = 5'h0A,
        SUB_HALF_REG = 5'h0B,
        SUB_WORD_IMM = 5'h12,
        SUB_WORD_REG = 5'h13
    } subop_e;

    typedef enum logic [1:0] {
        LANE_BYTE,
        LANE_HALF,
        LANE_WORD
    } lane_e;

    typedef struct packed {
        logic  valid;
        logic  brev;
        lane_e lane;
        logic  use_imm;
        logic  full64;
    } ctrl_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c.valid   = 1'b0;
        c.brev    = 1'b0;
        c.lane    = LANE_BYTE;
        c.use_imm = 1'b0;
        c.full64  = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/srx_decode.sv
module srx_decode
    import srx_pkg::*;
(
    input  logic               mode_64,
    input  logic               op_group,
    input  logic [SUBOP_W-1:0] subop,
    output ctrl_t              ctrl
);
    always_comb begin
        ctrl = ctrl_idle();
        if (!op_group) begin
            ctrl.full64 = 1'b0;
            case (subop)
                SUB_BREV:     begin ctrl.valid = 1'b1; ctrl.brev = 1'b1; end
                SUB_BYTE_IMM: begin ctrl.valid = 1'b1; ctrl.lane = LANE_BYTE; ctrl.use_imm = 1'b1; end
                SUB_BYTE_REG: begin ctrl.valid = 1'b1; ctrl.lane = LANE_BYTE; end
                SUB_HALF_IMM: begin ctrl.valid = 1'b1; ctrl.lane = LANE_HALF; ctrl.use_imm = 1'b1; end
                SUB_HALF_REG: begin ctrl.valid = 1'b1; ctrl.lane = LANE_HALF; end
                default:      ctrl.valid = 1'b0;
            endcase
        end else if (mode_64) begin
            ctrl.full64 = 1'b1;
            case (subop)
                SUB_BYTE_IMM: begin ctrl.valid = 1'b1; ctrl.lane = LANE_BYTE; ctrl.use_imm = 1'b1; end
                SUB_BYTE_REG: begin ctrl.valid = 1'b1; ctrl.lane = LANE_BYTE; end
                SUB_HALF_IMM: begin ctrl.valid = 1'b1; ctrl.lane = LANE_HALF; ctrl.use_imm = 1'b1; end
                SUB_HALF_REG: begin ctrl.valid = 1'b1; ctrl.lane = LANE_HALF; end
                SUB_WORD_IMM: begin ctrl.valid = 1'b1; ctrl.lane = LANE_WORD; ctrl.use_imm = 1'b1; end
                SUB_WORD_REG: begin ctrl.valid = 1'b1; ctrl.lane = LANE_WORD; end
                default:      ctrl.valid = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/srx_bitrev.sv
module srx_bitrev #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned REV_W = 16
) (
    input  logic [REV_W-1:0] src,
    output logic [XLEN-1:0]  res
);
    localparam int unsigned PAD_W = XLEN - REV_W;

    logic [REV_W-1:0] flipped;

    for (genvar i = 0; i < REV_W; i++) begin : g_flip
        assign flipped[REV_W-1-i] = src[i];
    end

    assign res = {{PAD_W{1'b0}}, flipped};
endmodule

// File: rtl/srx_replicate.sv
module srx_replicate
    import srx_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned IMM_W = 10
) (
    input  ctrl_t              ctrl,
    input  logic [IMM_W-1:0]   imm,
    input  logic [XLEN/2-1:0]  src,
    output logic [XLEN-1:0]    res
);
    localparam int unsigned WORD_W  = XLEN / 2;
    localparam int unsigned N_BYTE  = XLEN / 8;
    localparam int unsigned N_HALF  = XLEN / 16;
    localparam int unsigned N_WORD  = XLEN / WORD_W;

    logic [7:0]        b_val;
    logic [15:0]       h_val;
    logic [WORD_W-1:0] w_val;
    logic [XLEN-1:0]   rep_b, rep_h, rep_w, wide;

    assign b_val = ctrl.use_imm ? imm[7:0] : src[7:0];
    assign h_val = ctrl.use_imm ? {{(16-IMM_W){imm[IMM_W-1]}}, imm} : src[15:0];
    assign w_val = ctrl.use_imm ? {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm} : src;

    for (genvar g = 0; g < N_BYTE; g++) begin : g_byte
        assign rep_b[g*8 +: 8] = b_val;
    end
    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        assign rep_h[g*16 +: 16] = h_val;
    end
    for (genvar g = 0; g < N_WORD; g++) begin : g_word
        assign rep_w[g*WORD_W +: WORD_W] = w_val;
    end

    always_comb begin
        case (ctrl.lane)
            LANE_BYTE: wide = rep_b;
            LANE_HALF: wide = rep_h;
            default:   wide = rep_w;
        endcase
        if (ctrl.full64) res = wide;
        else             res = {{WORD_W{wide[WORD_W-1]}}, wide[WORD_W-1:0]};
    end
endmodule

// File: rtl/srx_repl_unit.sv
module srx_repl_unit
    import srx_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned IMM_W = 10,
    parameter int unsigned IDX_W = 5
) (
    input  logic               mode_64,
    input  logic               op_group,
    input  logic [SUBOP_W-1:0] subop,
    input  logic [IMM_W-1:0]   imm_field,
    input  logic [XLEN/2-1:0]  src_lo,
    input  logic [IDX_W-1:0]   dest_idx,
    output logic [XLEN-1:0]    wr_data,
    output logic               wr_en,
    output logic               illegal_op
);
    localparam int unsigned REV_W = 16;

    ctrl_t           ctrl;
    logic [XLEN-1:0] brev_res, rep_res;

    srx_decode u_dec (
        .mode_64  (mode_64),
        .op_group (op_group),
        .subop    (subop),
        .ctrl     (ctrl)
    );

    srx_bitrev #(.XLEN(XLEN), .REV_W(REV_W)) u_brev (
        .src (src_lo[REV_W-1:0]),
        .res (brev_res)
    );

    srx_replicate #(.XLEN(XLEN), .IMM_W(IMM_W)) u_rep (
        .ctrl (ctrl),
        .imm  (imm_field),
        .src  (src_lo),
        .res  (rep_res)
    );

    always_comb begin
        if (!ctrl.valid)   wr_data = '0;
        else if (ctrl.brev) wr_data = brev_res;
        else               wr_data = rep_res;
    end

    assign wr_en      = ctrl.valid && (dest_idx != '0);
    assign illegal_op = !ctrl.valid;
endmodule

// File: rtl/srx_repl_checker.sv
module srx_repl_checker #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned IDX_W = 5
) (
    input logic             mode_64,
    input logic             op_group,
    input logic [4:0]       subop,
    input logic [7:0]       imm_byte,
    input logic [7:0]       src_byte,
    input logic [IDX_W-1:0] dest_idx,
    input logic [XLEN-1:0]  wr_data,
    input logic             wr_en,
    input logic             illegal_op
);
    localparam int unsigned HW = XLEN / 2;

    always_comb begin
        AST_NO_WRITE_ON_ILLEGAL: assert (!(wr_en && illegal_op)) else $error("write with illegal op"); // R11
        AST_ILLEGAL_ZERO_DATA: assert (!illegal_op || wr_data == '0) else $error("illegal op data not zero"); // R11
        AST_DEST_ZERO_NO_WRITE: assert (dest_idx != '0 || !wr_en) else $error("write to index zero"); // R10
        AST_WIDE_IN_NARROW_MODE: assert (mode_64 || !op_group || illegal_op) else $error("wide op in 32-bit mode"); // R12
        AST_BREV_HIGH_ZERO: assert (op_group || subop != 5'h1B || wr_data[XLEN-1:16] == '0) else $error("bit-reverse high bits"); // R1
        AST_NARROW_SEXT: assert (op_group || illegal_op || subop == 5'h1B
                                 || wr_data[XLEN-1:HW] == {HW{wr_data[HW-1]}}) else $error("narrow not sign-extended"); // R6
        AST_BYTE_IMM_LANES: assert (op_group || subop != 5'h02
                                    || (wr_data[7:0] == imm_byte && wr_data[31:24] == imm_byte)) else $error("byte imm lanes"); // R2
        AST_BYTE_REG_LANES: assert (op_group || subop != 5'h03
                                    || (wr_data[15:8] == src_byte && wr_data[23:16] == src_byte)) else $error("byte reg lanes"); // R3
    end
endmodule

bind srx_repl_unit srx_repl_checker #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
    .mode_64    (mode_64),
    .op_group   (op_group),
    .subop      (subop),
    .imm_byte   (imm_field[7:0]),
    .src_byte   (src_lo[7:0]),
    .dest_idx   (dest_idx),
    .wr_data    (wr_data),
    .wr_en      (wr_en),
    .illegal_op (illegal_op)
);

// File: tb/srx_repl_unit_test.sv
module srx_repl_unit_test;

    logic        clk = 1'b0;
    logic        mode_64 = 1'b1;
    logic        op_group = 1'b0;
    logic [4:0]  subop = 5'h00;
    logic [9:0]  imm_field = '0;
    logic [31:0] src_lo = '0;
    logic [4:0]  dest_idx = 5'd1;
    logic [63:0] wr_data;
    logic        wr_en;
    logic        illegal_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    srx_repl_unit uut (
        .mode_64    (mode_64),
        .op_group   (op_group),
        .subop      (subop),
        .imm_field  (imm_field),
        .src_lo     (src_lo),
        .dest_idx   (dest_idx),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .illegal_op (illegal_op)
    );

    task automatic check_val(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic g, input logic [4:0] op,
                         input logic [9:0] imm, input logic [31:0] src, input logic [4:0] dst);
        @(negedge clk);
        mode_64 = m; op_group = g; subop = op; imm_field = imm; src_lo = src; dest_idx = dst;
        #1;
    endtask

    task automatic t_initial;
        // code 0x00 in narrow group at start: invalid, no write, zero data
        #1;
        check_val("R11 init illegal", {63'b0, illegal_op}, 64'd1);
        check_val("R11 init wr_en", {63'b0, wr_en}, 64'd0);
        check_val("R11 init data", wr_data, 64'd0);
    endtask

    task automatic t_bitrev;
        logic [63:0] exp;
        drive(1, 0, 5'h1B, 10'h0, 32'hFFFF_1234, 5'd3);
        check_val("R1 bitrev 1234", wr_data, 64'h0000_0000_0000_2C48);
        drive(1, 0, 5'h1B, 10'h0, 32'h0000_0001, 5'd3);
        check_val("R1 bitrev 0001", wr_data, 64'h0000_0000_0000_8000);
        drive(0, 0, 5'h1B, 10'h0, 32'hABCD_F00F, 5'd3);
        exp = '0;
        for (int i = 0; i < 16; i++) exp[15-i] = src_lo[i];
        check_val("R1 bitrev loop", wr_data, exp);
        check_val("R1 wr_en", {63'b0, wr_en}, 64'd1);
    endtask

    task automatic t_narrow_byte;
        drive(1, 0, 5'h02, 10'h35A, 32'h0, 5'd4);
        check_val("R2 byte imm", wr_data, 64'h0000_0000_5A5A_5A5A);
        drive(1, 0, 5'h02, 10'h0A5, 32'h0, 5'd4);
        check_val("R6 byte imm neg", wr_data, 64'hFFFF_FFFF_A5A5_A5A5);
        drive(0, 0, 5'h03, 10'h3FF, 32'h3333_44C3, 5'd4);
        check_val("R3 byte reg", wr_data, 64'hFFFF_FFFF_C3C3_C3C3);
    endtask

    task automatic t_narrow_half;
        drive(1, 0, 5'h0A, 10'h1FF, 32'h0, 5'd5);
        check_val("R4 half imm pos", wr_data, 64'h0000_0000_01FF_01FF);
        drive(1, 0, 5'h0A, 10'h200, 32'h0, 5'd5);
        check_val("R4 half imm neg", wr_data, 64'hFFFF_FFFF_FE00_FE00);
        drive(1, 0, 5'h0B, 10'h0, 32'hFFFF_7ABC, 5'd5);
        check_val("R5 half reg pos", wr_data, 64'h0000_0000_7ABC_7ABC);
        drive(1, 0, 5'h0B, 10'h0, 32'h0000_8001, 5'd5);
        check_val("R6 half reg neg", wr_data, 64'hFFFF_FFFF_8001_8001);
    endtask

    task automatic t_wide;
        drive(1, 1, 5'h02, 10'h33C, 32'h0, 5'd6);
        check_val("R7 byte x8 imm", wr_data, 64'h3C3C_3C3C_3C3C_3C3C);
        drive(1, 1, 5'h03, 10'h0, 32'h1234_5681, 5'd6);
        check_val("R7 byte x8 reg", wr_data, 64'h8181_8181_8181_8181);
        drive(1, 1, 5'h0A, 10'h3FF, 32'h0, 5'd6);
        check_val("R8 half x4 imm neg", wr_data, 64'hFFFF_FFFF_FFFF_FFFF);
        drive(1, 1, 5'h0A, 10'h155, 32'h0, 5'd6);
        check_val("R8 half x4 imm pos", wr_data, 64'h0155_0155_0155_0155);
        drive(1, 1, 5'h0B, 10'h0, 32'h0000_BEEF, 5'd6);
        check_val("R8 half x4 reg", wr_data, 64'hBEEF_BEEF_BEEF_BEEF);
        drive(1, 1, 5'h12, 10'h201, 32'h0, 5'd6);
        check_val("R9 word imm neg", wr_data, 64'hFFFF_FE01_FFFF_FE01);
        drive(1, 1, 5'h12, 10'h0FF, 32'h0, 5'd6);
        check_val("R9 word imm pos", wr_data, 64'h0000_00FF_0000_00FF);
        drive(1, 1, 5'h13, 10'h0, 32'hCAFE_F00D, 5'd6);
        check_val("R9 word reg", wr_data, 64'hCAFE_F00D_CAFE_F00D);
        check_val("R9 wr_en", {63'b0, wr_en}, 64'd1);
    endtask

    task automatic t_dest_zero;
        drive(1, 0, 5'h02, 10'h011, 32'h0, 5'd0);
        check_val("R10 legal dst0 wr_en", {63'b0, wr_en}, 64'd0);
        check_val("R10 legal dst0 illegal", {63'b0, illegal_op}, 64'd0);
        drive(1, 0, 5'h02, 10'h011, 32'h0, 5'd31);
        check_val("R10 legal dst31 wr_en", {63'b0, wr_en}, 64'd1);
        drive(1, 0, 5'h07, 10'h011, 32'h0, 5'd0);
        check_val("R10 illegal dst0 wr_en", {63'b0, wr_en}, 64'd0);
        check_val("R11 illegal dst0 flag", {63'b0, illegal_op}, 64'd1);
        check_val("R11 illegal dst0 data", wr_data, 64'd0);
    endtask

    task automatic t_illegal;
        drive(1, 0, 5'h12, 10'h0FF, 32'hFFFF_FFFF, 5'd9);
        check_val("R11 narrow 0x12 flag", {63'b0, illegal_op}, 64'd1);
        check_val("R11 narrow 0x12 wr_en", {63'b0, wr_en}, 64'd0);
        check_val("R11 narrow 0x12 data", wr_data, 64'd0);
        drive(1, 1, 5'h1B, 10'h0, 32'hFFFF_FFFF, 5'd9);
        check_val("R11 wide 0x1B flag", {63'b0, illegal_op}, 64'd1);
        check_val("R11 wide 0x1B data", wr_data, 64'd0);
    endtask

    task automatic t_mode32;
        drive(0, 1, 5'h02, 10'h0AA, 32'h0, 5'd7);
        check_val("R12 wide in 32 flag", {63'b0, illegal_op}, 64'd1);
        check_val("R12 wide in 32 wr_en", {63'b0, wr_en}, 64'd0);
        drive(0, 1, 5'h13, 10'h0, 32'h1111_2222, 5'd7);
        check_val("R12 wide word in 32 data", wr_data, 64'd0);
    endtask

    initial begin
        t_initial();
        t_bitrev();
        t_narrow_byte();
        t_narrow_half();
        t_wide();
        t_dest_zero();
        t_illegal();
        t_mode32();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule